// File: doc/BRIEF.md
# Consumer IR Wake-Up Pattern Matcher

This block sits behind the bit and cell recovery logic of a consumer infrared receiver. It decides whether a received remote-control command is the one chosen to wake the system. Upstream logic hands it one strobe per decoded bit, or per Manchester cell for RC6 frames, together with an end-of-message strobe and a NEC repeat strobe. Each bit is shifted into an 88-bit window. At the decision point the window is compared with an 11-byte pattern, and only the positions enabled by an 11-byte mask take part.

Software programs the block through a small byte-wide register file. The pattern bank and the mask bank are both reached through one index register and one data port, and each data access steps to the next byte. A length register tells the block how many RC6 cells make up a complete message. Results are kept as sticky flags that software clears by writing ones. Each flag that has its enable bit set drives the wake output.

Top module: `cirw_wake_matcher`

## Requirements
- R1: After reset every register reads 0x00, all status flags are clear, `wake` is low and `reg_rdata` is 0x00.
- R2: The registers sit at these offsets: control 0, status 1, event enable 2, index 3, data port 4, RC6 length 5. A read strobed in one cycle presents its value on `reg_rdata` from the next cycle.
- R3: Index register bits 5:4 select a bank: 01 (value 0x10) is the pattern bank and 10 (value 0x20) is the mask bank. Bits 3:0 give the byte address. Every read or write of the data port accesses the addressed byte of the selected bank and then advances the address. After byte 10 the address wraps to 0. Reading the index register returns the bank and the current address.
- R4: Each accepted bit enters window bit 0, which is bit 0 of byte 0, and older bits move one place up. When control bit 3 is set, each incoming bit is inverted before it is stored.
- R5: In protocols other than RC6 (control bits 5:4 not equal to 2), an end-of-message strobe compares the window. If ((window XOR pattern) AND mask) is zero over all 88 bits, the match flag (status bit 0) is set. A mask bit of 0 removes that position from the comparison.
- R6: A comparison that finds any differing masked bit leaves the match flag clear.
- R7: In RC6 mode (control bits 5:4 = 2), the comparison is made in the cycle after the cell that brings the count of cells since the last end-of-message up to the length register value. An end-of-message strobe in RC6 mode makes no comparison.
- R8: An end-of-message strobe sets status bit 1. The buffer flag (status bit 2) is set once 88 bits have been received since the last end-of-message. A repeat strobe sets status bit 4, but only in NEC mode (control bits 5:4 = 1).
- R9: Writing status with a 1 in bit 0, 1, 2 or 4 clears that flag. A 0 leaves the flag unchanged.
- R10: `wake` is high exactly while some status bit n in 0..2 is set and event-enable bit n is set. The repeat flag never drives `wake`.
- R11: While control bit 0 (wake enable) is clear, the window and the bit count are held at zero and no status flag can be set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| cell_valid | input | 1 | One decoded bit or cell is present |
| cell_bit | input | 1 | Value of that bit or cell |
| msg_end | input | 1 | End-of-message strobe |
| nec_repeat | input | 1 | NEC repeat-frame strobe |
| wake | output | 1 | Wake event request |

## Verification
Software cannot read the window directly, so an error in it shows up only at the next comparison. A shift in the wrong direction, a lost inversion or a stale bit turns an expected match flag into a miss, or a miss into a match, one cycle after the decision strobe. Address pointer faults show up at once in the next data-port read, most clearly when the address wraps after byte 10 or when access starts at a byte other than 0. A wrong bit count appears as an RC6 match that is missed or comes early when no end-of-message is sent. It can also appear as a buffer flag raised one bit before or after the 88th bit.

// File: rtl/cirw_pkg.sv
package cirw_pkg;
    localparam logic [3:0] A_CTRL = 4'd0;
    localparam logic [3:0] A_STS  = 4'd1;
    localparam logic [3:0] A_EN   = 4'd2;
    localparam logic [3:0] A_IDX  = 4'd3;
    localparam logic [3:0] A_DATA = 4'd4;
    localparam logic [3:0] A_CSL  = 4'd5;

    localparam logic [1:0] BANK_CMP = 2'b01;
    localparam logic [1:0] BANK_MSK = 2'b10;

    typedef enum logic [1:0] {
        PROTO_RC5  = 2'd0,
        PROTO_NEC  = 2'd1,
        PROTO_RC6  = 2'd2,
        PROTO_RSVD = 2'd3
    } proto_e;

    localparam logic [7:0] STS_W1C_MASK = 8'h17;
endpackage

// File: rtl/cirw_regs.sv
module cirw_regs
    import cirw_pkg::*;
#(
    parameter int unsigned NBYTES = 11,
    parameter int unsigned PW     = $clog2(NBYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [3:0]             addr,
    input  logic [7:0]             wdata,
    input  logic [7:0]             status_i,
    output logic [7:0]             rdata_o,
    output logic                   wake_en_o,
    output logic                   invert_o,
    output proto_e                 proto_o,
    output logic [2:0]             evt_en_o,
    output logic [7:0]             csl_o,
    output logic [NBYTES-1:0][7:0] cmp_o,
    output logic [NBYTES-1:0][7:0] msk_o,
    output logic                   sts_wr_o
);
    typedef struct packed {
        logic                   wake_en;
        logic                   invert;
        logic [1:0]             proto;
        logic [2:0]             en;
        logic [1:0]             bank;
        logic [PW-1:0]          ptr;
        logic [7:0]             csl;
        logic [NBYTES-1:0][7:0] cmp;
        logic [NBYTES-1:0][7:0] msk;
        logic [7:0]             rdata;
    } regs_t;

    regs_t r_d, r_q;
    logic  data_acc;
    logic  idx_wr;
    logic  ptr_ok;
    logic [7:0] bank_byte;

    always_comb begin
        r_d      = r_q;
        data_acc = (wr_en || rd_en) && (addr == A_DATA);
        idx_wr   = wr_en && (addr == A_IDX);
        ptr_ok   = int'(r_q.ptr) < NBYTES;

        bank_byte = 8'h00;
        if (ptr_ok) begin
            if (r_q.bank == BANK_CMP)      bank_byte = r_q.cmp[r_q.ptr];
            else if (r_q.bank == BANK_MSK) bank_byte = r_q.msk[r_q.ptr];
        end

        if (wr_en) begin
            case (addr)
                A_CTRL: begin
                    r_d.wake_en = wdata[0];
                    r_d.invert  = wdata[3];
                    r_d.proto   = wdata[5:4];
                end
                A_EN:  r_d.en = wdata[2:0];
                A_IDX: begin
                    r_d.bank = wdata[5:4];
                    r_d.ptr  = wdata[PW-1:0];
                end
                A_DATA: begin
                    if (ptr_ok) begin
                        if (r_q.bank == BANK_CMP)      r_d.cmp[r_q.ptr] = wdata;
                        else if (r_q.bank == BANK_MSK) r_d.msk[r_q.ptr] = wdata;
                    end
                end
                A_CSL: r_d.csl = wdata;
                default: ;
            endcase
        end

        if (data_acc && !idx_wr) begin
            if (int'(r_q.ptr) >= NBYTES - 1) r_d.ptr = '0;
            else                             r_d.ptr = r_q.ptr + 1'b1;
        end

        if (rd_en) begin
            case (addr)
                A_CTRL:  r_d.rdata = {2'b00, r_q.proto, r_q.invert, 2'b00, r_q.wake_en};
                A_STS:   r_d.rdata = status_i;
                A_EN:    r_d.rdata = {5'b00000, r_q.en};
                A_IDX:   r_d.rdata = {2'b00, r_q.bank, 4'(r_q.ptr)};
                A_DATA:  r_d.rdata = bank_byte;
                A_CSL:   r_d.rdata = r_q.csl;
                default: r_d.rdata = 8'h00;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rdata_o   = r_q.rdata;
    assign wake_en_o = r_q.wake_en;
    assign invert_o  = r_q.invert;
    assign proto_o   = proto_e'(r_q.proto);
    assign evt_en_o  = r_q.en;
    assign csl_o     = r_q.csl;
    assign cmp_o     = r_q.cmp;
    assign msk_o     = r_q.msk;
    assign sts_wr_o  = wr_en && (addr == A_STS);

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !idx_wr && int'(r_q.ptr) == NBYTES - 1) |=> (r_q.ptr == '0)); // R3
endmodule

// File: rtl/cirw_window.sv
module cirw_window #(
    parameter int unsigned WIN_BITS = 88,
    parameter int unsigned CW       = $clog2(WIN_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                invert,
    input  logic                bit_valid,
    input  logic                bit_i,
    input  logic                msg_end,
    output logic [WIN_BITS-1:0] window_o,
    output logic [CW-1:0]       count_o,
    output logic                shifted_o
);
    typedef struct packed {
        logic [WIN_BITS-1:0] win;
        logic [CW-1:0]       cnt;
        logic                shifted;
    } win_t;

    win_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (!enable) begin
            w_d = '0;
        end else begin
            w_d.shifted = bit_valid;
            if (bit_valid) begin
                w_d.win = {w_q.win[WIN_BITS-2:0], bit_i ^ invert};
                if (w_q.cnt != CW'(WIN_BITS)) w_d.cnt = w_q.cnt + 1'b1;
            end
            if (msg_end) w_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign window_o  = w_q.win;
    assign count_o   = w_q.cnt;
    assign shifted_o = w_q.shifted;

    AST_WIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (window_o == '0 && count_o == '0)); // R11
    AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o <= CW'(WIN_BITS))); // R8
endmodule

// File: rtl/cirw_status.sv
module cirw_status
    import cirw_pkg::*;
#(
    parameter int unsigned NBYTES   = 11,
    parameter int unsigned WIN_BITS = NBYTES * 8,
    parameter int unsigned CW       = $clog2(WIN_BITS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   enable,
    input  proto_e                 proto,
    input  logic [WIN_BITS-1:0]    window,
    input  logic [NBYTES-1:0][7:0] cmp,
    input  logic [NBYTES-1:0][7:0] msk,
    input  logic [CW-1:0]          count,
    input  logic                   shifted,
    input  logic [7:0]             csl,
    input  logic                   msg_end,
    input  logic                   nec_repeat,
    input  logic                   clr_wr,
    input  logic [7:0]             clr_mask,
    input  logic [2:0]             evt_en,
    output logic [7:0]             status_o,
    output logic                   wake_o
);
    typedef struct packed {
        logic [7:0] sts;
    } sts_t;

    sts_t s_d, s_q;
    logic [NBYTES-1:0] byte_ok;
    logic all_ok;
    logic trig_cmp;
    logic [7:0] set_v;
    logic [7:0] clr_v;

    for (genvar k = 0; k < NBYTES; k++) begin : g_cmp
        assign byte_ok[k] = ((window[8*k +: 8] ^ cmp[k]) & msk[k]) == 8'h00;
    end

    always_comb begin
        s_d    = s_q;
        all_ok = &byte_ok;
        if (proto == PROTO_RC6) trig_cmp = enable && shifted && (int'(count) == int'(csl));
        else                    trig_cmp = enable && msg_end;

        set_v    = 8'h00;
        set_v[0] = trig_cmp && all_ok;
        set_v[1] = enable && msg_end;
        set_v[2] = enable && shifted && (int'(count) == WIN_BITS);
        set_v[4] = enable && nec_repeat && (proto == PROTO_NEC);

        clr_v = clr_wr ? (clr_mask & STS_W1C_MASK) : 8'h00;
        s_d.sts = (s_q.sts & ~clr_v) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign status_o = s_q.sts;
    assign wake_o   = |(s_q.sts[2:0] & evt_en);

    AST_OFF_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ((status_o & ~$past(status_o)) == 8'h00)); // R11
    AST_MATCH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[0]) |-> $past(trig_cmp)); // R5
    AST_W1C_END: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_mask[1] && !(enable && msg_end)) |=> !status_o[1]); // R9
endmodule

// File: rtl/cirw_wake_matcher.sv
module cirw_wake_matcher
    import cirw_pkg::*;
#(
    parameter int unsigned NBYTES = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr_en,
    input  logic       reg_rd_en,
    input  logic [3:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       cell_valid,
    input  logic       cell_bit,
    input  logic       msg_end,
    input  logic       nec_repeat,
    output logic       wake
);
    localparam int unsigned WIN_BITS = NBYTES * 8;
    localparam int unsigned CW       = $clog2(WIN_BITS + 1);

    logic                   wake_en;
    logic                   invert;
    proto_e                 proto;
    logic [2:0]             evt_en;
    logic [7:0]             csl;
    logic [NBYTES-1:0][7:0] cmp;
    logic [NBYTES-1:0][7:0] msk;
    logic                   sts_wr;
    logic [7:0]             status;
    logic [WIN_BITS-1:0]    window;
    logic [CW-1:0]          count;
    logic                   shifted;

    cirw_regs #(.NBYTES(NBYTES)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .rd_en(reg_rd_en),
        .addr(reg_addr), .wdata(reg_wdata), .status_i(status), .rdata_o(reg_rdata),
        .wake_en_o(wake_en), .invert_o(invert), .proto_o(proto), .evt_en_o(evt_en),
        .csl_o(csl), .cmp_o(cmp), .msk_o(msk), .sts_wr_o(sts_wr)
    );

    cirw_window #(.WIN_BITS(WIN_BITS), .CW(CW)) u_window (
        .clk(clk), .rst_n(rst_n), .enable(wake_en), .invert(invert),
        .bit_valid(cell_valid), .bit_i(cell_bit), .msg_end(msg_end),
        .window_o(window), .count_o(count), .shifted_o(shifted)
    );

    cirw_status #(.NBYTES(NBYTES), .WIN_BITS(WIN_BITS), .CW(CW)) u_status (
        .clk(clk), .rst_n(rst_n), .enable(wake_en), .proto(proto),
        .window(window), .cmp(cmp), .msk(msk), .count(count), .shifted(shifted),
        .csl(csl), .msg_end(msg_end), .nec_repeat(nec_repeat),
        .clr_wr(sts_wr), .clr_mask(reg_wdata), .evt_en(evt_en),
        .status_o(status), .wake_o(wake)
    );
endmodule

// File: tb/tb_cirw_wake_matcher.sv
`timescale 1ns/1ps
module tb_cirw_wake_matcher;
    localparam logic [3:0] A_CTRL = 4'd0, A_STS = 4'd1, A_EN = 4'd2,
                           A_IDX = 4'd3, A_DATA = 4'd4, A_CSL = 4'd5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [3:0] reg_addr = 4'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic cell_valid = 1'b0, cell_bit = 1'b0, msg_end = 1'b0, nec_repeat = 1'b0;
    logic wake;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic rd_seen = 1'b0;
    logic [7:0] exp_q[$];
    string tag_q[$];

    cirw_wake_matcher dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cell_valid(cell_valid), .cell_bit(cell_bit), .msg_end(msg_end),
        .nec_repeat(nec_repeat), .wake(wake)
    );

    always #2.5 clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) rd_seen <= reg_rd_en;

    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            chk(t, {24'd0, reg_rdata}, {24'd0, e});
        end
    end

    task automatic wr(logic [3:0] a, logic [7:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, logic [7:0] e, string tag);
        reg_rd_en = 1'b1; reg_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        reg_rd_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(logic b);
        cell_valid = 1'b1; cell_bit = b;
        @(negedge clk);
        cell_valid = 1'b0;
    endtask

    task automatic send_word(logic [31:0] v, int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic end_msg();
        msg_end = 1'b1;
        @(negedge clk);
        msg_end = 1'b0;
    endtask

    task automatic pulse_rep();
        nec_repeat = 1'b1;
        @(negedge clk);
        nec_repeat = 1'b0;
    endtask

    function automatic logic [7:0] cmpv(int k);
        if (k == 0) return 8'h5B;
        if (k == 1) return 8'h1A;
        return 8'h30 + 8'(k);
    endfunction

    localparam logic [31:0] V5 = 32'h1A5B;
    localparam logic [31:0] P6 = 32'hC3A5F;

    initial begin
        idle(4);
        rst_n = 1'b1;
        chk("R1 wake after reset", {31'd0, wake}, 0);
        chk("R1 rdata after reset", {24'd0, reg_rdata}, 0);
        rd(A_CTRL, 8'h00, "R1 ctrl reset");
        rd(A_STS,  8'h00, "R1 status reset");
        rd(A_EN,   8'h00, "R1 enable reset");
        rd(A_IDX,  8'h00, "R1 index reset");
        rd(A_CSL,  8'h00, "R1 length reset");

        // R3 bank loading and readback
        wr(A_IDX, 8'h10);
        for (int k = 0; k < 11; k++) wr(A_DATA, cmpv(k));
        wr(A_IDX, 8'h20);
        wr(A_DATA, 8'hFF); wr(A_DATA, 8'h17);
        for (int k = 2; k < 11; k++) wr(A_DATA, 8'h00);
        wr(A_IDX, 8'h10);
        for (int k = 0; k < 11; k++) rd(A_DATA, cmpv(k), "R3 pattern readback");
        rd(A_DATA, cmpv(0), "R3 address wrap to byte 0");
        rd(A_IDX, 8'h11, "R3 index readback");
        wr(A_IDX, 8'h14);
        rd(A_DATA, 8'h34, "R3 start at byte 4");
        wr(A_IDX, 8'h2A);
        rd(A_DATA, 8'h00, "R3 mask byte 10");
        rd(A_DATA, 8'hFF, "R3 mask wrap");
        rd(A_DATA, 8'h17, "R3 mask byte 1");

        // R5 match at end in RC5 mode
        wr(A_CTRL, 8'h01);
        rd(A_CTRL, 8'h01, "R2 ctrl readback");
        wr(A_EN, 8'h01);
        send_word(V5, 13);
        end_msg();
        rd(A_STS, 8'h03, "R5 match and end flags");
        chk("R10 wake on enabled match", {31'd0, wake}, 1);
        wr(A_STS, 8'h01);
        rd(A_STS, 8'h02, "R9 clear match only");
        chk("R10 wake low with end flag not enabled", {31'd0, wake}, 0);
        wr(A_EN, 8'h03);
        chk("R10 wake on enabled end flag", {31'd0, wake}, 1);
        wr(A_STS, 8'h02);
        rd(A_STS, 8'h00, "R9 clear end flag");
        chk("R10 wake low after clear", {31'd0, wake}, 0);
        wr(A_EN, 8'h01);

        // R5 masked-out toggle position ignored
        send_word(V5 ^ 32'h800, 13);
        end_msg();
        rd(A_STS, 8'h03, "R5 masked bit ignored");
        wr(A_STS, 8'h17);

        // R6 mismatch
        send_word(V5 ^ 32'h1, 13);
        end_msg();
        rd(A_STS, 8'h02, "R6 mismatch no match flag");
        chk("R6 no wake on mismatch", {31'd0, wake}, 0);
        wr(A_STS, 8'h00);
        rd(A_STS, 8'h02, "R9 writing zero keeps flag");
        wr(A_STS, 8'h17);

        // R4 inversion
        wr(A_CTRL, 8'h09);
        send_word(~V5, 13);
        end_msg();
        rd(A_STS, 8'h03, "R4 inverted input matches");
        wr(A_STS, 8'h17);

        // R8 repeat flag only in NEC mode
        wr(A_CTRL, 8'h01);
        pulse_rep();
        rd(A_STS, 8'h00, "R8 repeat ignored outside NEC");
        wr(A_CTRL, 8'h11);
        pulse_rep();
        rd(A_STS, 8'h10, "R8 repeat flag in NEC");
        chk("R10 repeat never wakes", {31'd0, wake}, 0);
        wr(A_STS, 8'h10);
        rd(A_STS, 8'h00, "R9 clear repeat flag");

        // R7 RC6 cell-count comparison
        wr(A_IDX, 8'h10);
        wr(A_DATA, 8'h5F); wr(A_DATA, 8'h3A); wr(A_DATA, 8'h0C);
        wr(A_IDX, 8'h20);
        wr(A_DATA, 8'hFF); wr(A_DATA, 8'hFF); wr(A_DATA, 8'h0F);
        wr(A_CSL, 8'd20);
        rd(A_CSL, 8'd20, "R2 length readback");
        wr(A_CTRL, 8'h21);
        end_msg();
        wr(A_STS, 8'h17);
        send_word(P6, 20);
        idle(1);
        rd(A_STS, 8'h01, "R7 match after programmed cell count");
        wr(A_STS, 8'h17);
        end_msg();
        rd(A_STS, 8'h02, "R7 end makes no compare in RC6");
        wr(A_STS, 8'h17);
        send_word(P6 ^ 32'h4, 20);
        idle(1);
        rd(A_STS, 8'h00, "R6 RC6 mismatch");
        end_msg();
        wr(A_STS, 8'h17);

        // R8 buffer flag at 88 bits
        wr(A_CTRL, 8'h01);
        end_msg();
        wr(A_STS, 8'h17);
        for (int i = 0; i < 87; i++) send_bit(1'b0);
        idle(1);
        rd(A_STS, 8'h00, "R8 no buffer flag at 87 bits");
        send_bit(1'b0);
        idle(1);
        rd(A_STS, 8'h04, "R8 buffer flag at 88 bits");
        wr(A_EN, 8'h04);
        chk("R10 wake on buffer flag", {31'd0, wake}, 1);
        wr(A_STS, 8'h17);
        wr(A_EN, 8'h01);

        // R11 disabled block holds window and sets nothing
        wr(A_IDX, 8'h10); wr(A_DATA, 8'h00);
        wr(A_IDX, 8'h20);
        wr(A_DATA, 8'hFF); wr(A_DATA, 8'h00); wr(A_DATA, 8'h00);
        wr(A_CTRL, 8'h10);
        send_word(32'hFF, 8);
        end_msg();
        pulse_rep();
        rd(A_STS, 8'h00, "R11 no flags while disabled");
        chk("R11 no wake while disabled", {31'd0, wake}, 0);
        wr(A_CTRL, 8'h01);
        end_msg();
        rd(A_STS, 8'h03, "R11 window held at zero");
        wr(A_STS, 8'h17);
        send_word(32'hFF, 8);
        end_msg();
        rd(A_STS, 8'h02, "R4 ones in window mismatch");
        idle(3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule